// File: doc/BRIEF.md
# Self-ID Receive Stream Sequencer

This block turns a raw receive buffer, gathered while the nodes on a serial bus identify themselves, into a clean, ordered stream of self-identification quadlets. The buffer comes in as a stream of 32-bit quadlets together with its byte count. The block removes framing markers and quadlets that are not in a valid pair. It also places the node's own self-ID quadlet at the point where it belongs in physical-ID order. The node's own quadlet is never present in the received buffer, so the block must insert it.

A start pulse loads the byte count, the node ID word and the locally built self-ID quadlet. The block then pulls quadlets through a valid/ready input and pushes the result through a valid/ready output. When the buffer has been fully consumed and the last quadlet delivered, it raises a one-cycle completion pulse. The pulse carries the physical ID, the root flag and whether the buffer held self-ID data at all. A saturating counter records how many quadlets were dropped as malformed.

Top module: `selfid_seq`

## Requirements
- R1: A buffer that is empty, or whose first quadlet is not 0x000000E0, is consumed in full. Nothing is emitted, and the completion pulse reports doneSelfId = 0. In every other case doneSelfId = 1.
- R2: Any quadlet equal to 0x000000E0 in a self-ID buffer is a begin marker. It is consumed as 4 bytes and never emitted.
- R3: A quadlet equal to 0x00000001 ends interpretation. The quadlets after it are still accepted, but none of them is emitted or counted as an error.
- R4: A quadlet followed by its bitwise complement forms a valid pair. The first quadlet alone is emitted and 8 bytes are consumed.
- R5: The own self-ID is emitted immediately before a valid quadlet q when (q & 0x3F800000) == (phyId + 1) << 24. As a result, a node with phyId 63 never inserts at this point.
- R6: When the byte count is exactly 8, the own self-ID is emitted before anything else from the buffer.
- R7: After the buffer is consumed, the own self-ID is emitted last when the root flag is 1 and phyId is not 0.
- R8: phyId is bits 5:0 of the node ID word and the root flag is bit 23. Both are captured at start and reported with the completion pulse.
- R9: A quadlet that is neither a marker nor the first half of a valid pair is dropped as 4 bytes. The quadlet after it is then examined afresh. errCount increments for each drop and saturates at its maximum.
- R10: The completion pulse lasts exactly one cycle per buffer and follows the last output transfer. Output data holds steady while outValid is high and outReady is low, and input and output are never offered in the same cycle.
- R11: After reset, outValid, inReady and donePulse are 0 and errCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a buffer; honoured only when idle |
| startBytes | input | CNT_W | Buffer length in bytes (multiple of 4) |
| nodeIdWord | input | 32 | Node ID word holding phyId and the root flag |
| ownSelfId | input | 32 | Locally built self-ID quadlet |
| inValid | input | 1 | Input quadlet valid |
| inData | input | 32 | Input quadlet |
| inReady | output | 1 | Block accepts an input quadlet |
| outValid | output | 1 | Output quadlet valid |
| outData | output | 32 | Output self-ID quadlet |
| outReady | input | 1 | Consumer accepts the output quadlet |
| donePulse | output | 1 | One-cycle completion pulse |
| donePhyId | output | 6 | Captured physical ID |
| doneRoot | output | 1 | Captured root flag |
| doneSelfId | output | 1 | Buffer was treated as self-ID data |
| errCount | output | ERR_W | Saturating count of dropped quadlets |

## Verification
The bench uses the default widths, CNT_W = 12 and ERR_W = 8. With ERR_W at 8, a single buffer holding a few hundred malformed quadlets is enough to drive the error counter into saturation. It sweeps every own-ID position on buses of two to six nodes, both with and without the root flag, and covers phyId 63, where no insertion point can exist. Input gaps and output backpressure are drawn at random, so every handshake stall is exercised while the expected stream is computed from the requirements alone.

// File: rtl/selfid_seq_pkg.sv
package selfid_seq_pkg;
  localparam logic [31:0] BEGIN_MARK = 32'h0000_00E0;
  localparam logic [31:0] END_MARK   = 32'h0000_0001;
  localparam logic [31:0] ID_MASK    = 32'h3F80_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_GET0, S_CLS, S_GET1, S_UNCONN, S_OWNPRE,
    S_PAIR, S_DRAIN, S_END, S_ROOTOWN, S_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic takeIn;
    logic loadHold;
    logic clrFirst;
    logic setNotSelf;
    logic incErr;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic remZero;
    logic first;
    logic notSelf;
    logic unconn;
    logic rootInsert;
    logic holdBegin;
    logic holdEnd;
    logic pairOk;
    logic ownBefore;
  } dpStat_t;
endpackage

// File: rtl/selfid_seq_dp.sv
module selfid_seq_dp
  import selfid_seq_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  output dpStat_t          stat,
  input  logic [CNT_W-1:0] startBytes,
  input  logic [31:0]      nodeIdWord,
  input  logic [31:0]      ownSelfId,
  input  logic [31:0]      inData,
  input  logic             outSelOwn,
  output logic [31:0]      outData,
  output logic [5:0]       phyIdQ,
  output logic             rootQ,
  output logic [ERR_W-1:0] errCount
);
  localparam int REM_W = CNT_W - 2;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [REM_W-1:0] remQ;
  logic [31:0]      hold;
  logic [31:0]      ownQ;
  logic             firstQ, notSelfQ, unconnQ;
  logic [31:0]      nextIdKey;
  logic             unusedBits;

  assign unusedBits = ^{nodeIdWord[31:24], nodeIdWord[22:6], startBytes[1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ     <= '0;
      hold     <= '0;
      ownQ     <= '0;
      phyIdQ   <= '0;
      rootQ    <= 1'b0;
      firstQ   <= 1'b0;
      notSelfQ <= 1'b0;
      unconnQ  <= 1'b0;
      errCount <= '0;
    end else begin
      if (ctl.loadStart) begin
        remQ     <= startBytes[CNT_W-1:2];
        ownQ     <= ownSelfId;
        phyIdQ   <= nodeIdWord[5:0];
        rootQ    <= nodeIdWord[23];
        firstQ   <= 1'b1;
        notSelfQ <= 1'b0;
        unconnQ  <= (startBytes == CNT_W'(8));
      end
      if (ctl.takeIn)     remQ     <= remQ - 1'b1;
      if (ctl.loadHold)   hold     <= inData;
      if (ctl.clrFirst)   firstQ   <= 1'b0;
      if (ctl.setNotSelf) notSelfQ <= 1'b1;
      if (ctl.incErr && errCount != ERR_MAX) errCount <= errCount + 1'b1;
    end
  end

  assign nextIdKey = {1'b0, ({1'b0, phyIdQ} + 7'd1), 24'd0};

  always_comb begin
    stat.remZero    = (remQ == '0);
    stat.first      = firstQ;
    stat.notSelf    = notSelfQ;
    stat.unconn     = unconnQ;
    stat.rootInsert = rootQ && (phyIdQ != 6'd0);
    stat.holdBegin  = (hold == BEGIN_MARK);
    stat.holdEnd    = (hold == END_MARK);
    stat.pairOk     = (inData == ~hold);
    stat.ownBefore  = ((hold & ID_MASK) == nextIdKey);
  end

  assign outData = outSelOwn ? ownQ : hold;
endmodule

// File: rtl/selfid_seq_ctl.sv
module selfid_seq_ctl
  import selfid_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    inValid,
  input  logic    outReady,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    inReady,
  output logic    outValid,
  output logic    outSelOwn,
  output logic    donePulse,
  output logic    doneSelfId
);
  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt       = state;
    ctl       = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    outSelOwn = 1'b0;
    donePulse = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.loadStart = 1'b1;
        nxt = S_GET0;
      end
      S_GET0: begin
        inReady = !stat.remZero;
        if (stat.remZero) nxt = S_END;
        else if (inValid) begin
          ctl.takeIn = 1'b1;
          ctl.loadHold = 1'b1;
          nxt = S_CLS;
        end
      end
      S_CLS: begin
        if (stat.first) begin
          ctl.clrFirst = 1'b1;
          if (!stat.holdBegin) begin
            ctl.setNotSelf = 1'b1;
            nxt = S_DRAIN;
          end else nxt = stat.unconn ? S_UNCONN : S_GET0;
        end
        else if (stat.holdBegin) nxt = S_GET0;
        else if (stat.holdEnd)   nxt = S_DRAIN;
        else if (stat.remZero) begin
          ctl.incErr = 1'b1;
          nxt = S_GET0;
        end
        else nxt = S_GET1;
      end
      S_GET1: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.takeIn = 1'b1;
          if (stat.pairOk) nxt = stat.ownBefore ? S_OWNPRE : S_PAIR;
          else begin
            ctl.incErr = 1'b1;
            ctl.loadHold = 1'b1;
            nxt = S_CLS;
          end
        end
      end
      S_UNCONN: begin
        outValid = 1'b1;
        outSelOwn = 1'b1;
        if (outReady) nxt = S_GET0;
      end
      S_OWNPRE: begin
        outValid = 1'b1;
        outSelOwn = 1'b1;
        if (outReady) nxt = S_PAIR;
      end
      S_PAIR: begin
        outValid = 1'b1;
        if (outReady) nxt = S_GET0;
      end
      S_DRAIN: begin
        inReady = !stat.remZero;
        if (stat.remZero) nxt = S_END;
        else if (inValid) ctl.takeIn = 1'b1;
      end
      S_END: nxt = (doneSelfId && stat.rootInsert) ? S_ROOTOWN : S_DONE;
      S_ROOTOWN: begin
        outValid = 1'b1;
        outSelOwn = 1'b1;
        if (outReady) nxt = S_DONE;
      end
      S_DONE: begin
        donePulse = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign doneSelfId = !stat.notSelf && !stat.first;
endmodule

// File: rtl/selfid_seq.sv
module selfid_seq
  import selfid_seq_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] startBytes,
  input  logic [31:0]      nodeIdWord,
  input  logic [31:0]      ownSelfId,
  input  logic             inValid,
  input  logic [31:0]      inData,
  output logic             inReady,
  output logic             outValid,
  output logic [31:0]      outData,
  input  logic             outReady,
  output logic             donePulse,
  output logic [5:0]       donePhyId,
  output logic             doneRoot,
  output logic             doneSelfId,
  output logic [ERR_W-1:0] errCount
);
  dpCtl_t  ctl;
  dpStat_t stat;
  logic    outSelOwn;

  selfid_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .outReady(outReady), .stat(stat), .ctl(ctl), .inReady(inReady),
    .outValid(outValid), .outSelOwn(outSelOwn), .donePulse(donePulse),
    .doneSelfId(doneSelfId)
  );

  selfid_seq_dp #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .startBytes(startBytes), .nodeIdWord(nodeIdWord), .ownSelfId(ownSelfId),
    .inData(inData), .outSelOwn(outSelOwn), .outData(outData),
    .phyIdQ(donePhyId), .rootQ(doneRoot), .errCount(errCount)
  );
endmodule

// File: rtl/selfid_seq_chk.sv
module selfid_seq_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outValid,
  input logic [31:0]      outData,
  input logic             outReady,
  input logic             donePulse,
  input logic [ERR_W-1:0] errCount
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R10

  AST_NO_IN_OUT_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!outValid && !inReady)); // R10

  AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> (errCount == $past(errCount) + 1'b1)); // R9
endmodule

bind selfid_seq selfid_seq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outData(outData), .outReady(outReady), .donePulse(donePulse),
  .errCount(errCount)
);

// File: tb/sim_selfid_seq.sv
module sim_selfid_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] startBytes = '0;
  logic [31:0] nodeIdWord = '0, ownSelfId = '0, inData = '0, outData;
  logic inValid = 1'b0, outReady = 1'b0;
  logic inReady, outValid, donePulse, doneRoot, doneSelfId;
  logic [5:0] donePhyId;
  logic [ERR_W-1:0] errCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfid_seq #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u0 (.*);

  int nChk = 0, nFail = 0;
  logic [31:0] bufQ [0:511];
  int bufN;
  logic [31:0] expQ [0:63];
  int expN, expErr;
  logic expSelf;
  logic [31:0] gotQ [0:63];
  int gotN;
  int gapMode = 0;

  task automatic chk(input bit ok, input string tag, input string what);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  function automatic logic [31:0] sidOf(input int k);
    return 32'h8040_0000 | (32'(k) << 24) | 32'(k);
  endfunction

  function automatic logic [31:0] ownOf(input int k);
    return 32'h8040_00F0 | (32'(k) << 24);
  endfunction

  // reference sequence computed from the requirements
  task automatic model(input logic [5:0] phy, input logic root, input logic [31:0] own);
    int i;
    expN = 0; expErr = 0;
    expSelf = (bufN > 0) && (bufQ[0] == 32'hE0);
    if (!expSelf) return;
    if (bufN == 2) begin expQ[expN] = own; expN++; end
    i = 0;
    while (i < bufN) begin
      if (bufQ[i] == 32'hE0) i++;
      else if (bufQ[i] == 32'h1) break;
      else if (i + 1 < bufN && bufQ[i+1] == ~bufQ[i]) begin
        if ((bufQ[i] & 32'h3F80_0000) == ((32'(phy) + 32'd1) << 24)) begin
          expQ[expN] = own; expN++;
        end
        expQ[expN] = bufQ[i]; expN++;
        i += 2;
      end else begin
        expErr++; i++;
      end
    end
    if (root && phy != 6'd0) begin expQ[expN] = own; expN++; end
  endtask

  task automatic runBuf(input logic [31:0] nodeW, input logic [31:0] own, input string tag);
    int idx, cyc, errBefore, errExp;
    bit fin;
    model(nodeW[5:0], nodeW[23], own);
    errBefore = int'(errCount);
    @(negedge clk);
    start = 1'b1; startBytes = CNT_W'(bufN * 4); nodeIdWord = nodeW; ownSelfId = own;
    @(negedge clk);
    start = 1'b0;
    idx = 0; gotN = 0; cyc = 0; fin = 0;
    while (!fin) begin
      if (donePulse) begin
        fin = 1;
        chk(idx == bufN, tag, $sformatf("inputs taken %0d expected %0d", idx, bufN));
        chk(gotN == expN, tag, $sformatf("outputs %0d expected %0d", gotN, expN));
        for (int k = 0; k < gotN && k < expN; k++)
          if (gotQ[k] != expQ[k]) begin
            chk(0, tag, $sformatf("out[%0d] %h expected %h", k, gotQ[k], expQ[k]));
            break;
          end
        chk(doneSelfId == expSelf, {tag, " R1"},
            $sformatf("doneSelfId %0b expected %0b", doneSelfId, expSelf));
        chk(donePhyId == nodeW[5:0] && doneRoot == nodeW[23], {tag, " R8"},
            $sformatf("phy/root %0d/%0b expected %0d/%0b", donePhyId, doneRoot, nodeW[5:0], nodeW[23]));
        errExp = errBefore + expErr;
        if (errExp > 255) errExp = 255;
        chk(int'(errCount) == errExp, {tag, " R9"},
            $sformatf("errCount %0d expected %0d", errCount, errExp));
      end else begin
        inValid = (idx < bufN) && (gapMode == 0 || $urandom_range(0, 2) != 0);
        inData = (idx < bufN) ? bufQ[idx] : 32'h0;
        outReady = (gapMode == 0 || $urandom_range(0, 2) != 0);
        if (outValid && outReady) begin
          if (gotN < 64) gotQ[gotN] = outData;
          gotN++;
        end
        if (inValid && inReady) idx++;
        cyc++;
        if (cyc > 20000) begin
          chk(0, tag, "stalled, done 0 expected 1");
          fin = 1;
        end
        @(negedge clk);
      end
    end
    inValid = 1'b0; outReady = 1'b0;
  endtask

  task automatic busBuf(input int nodes, input int own);
    bufN = 0;
    bufQ[bufN++] = 32'hE0;
    for (int k = 0; k < nodes; k++)
      if (k != own) begin
        bufQ[bufN++] = sidOf(k);
        bufQ[bufN++] = ~sidOf(k);
      end
    bufQ[bufN++] = 32'h1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nChk++; nFail++;
    $display("FAIL watchdog: run not finished, expected finish");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!outValid && !inReady && !donePulse && errCount == 0, "R11",
        $sformatf("ov/ir/dp/err %0b/%0b/%0b/%0d expected 0/0/0/0", outValid, inReady, donePulse, errCount));
    rstN = 1'b1;

    for (int g = 0; g < 2; g++) begin
      gapMode = g;
      // R1: not a self-ID buffer, and empty buffer
      bufN = 3; bufQ[0] = 32'h1234_5678; bufQ[1] = 32'hE0; bufQ[2] = ~32'h1234_5678;
      runBuf(32'h0080_0002, ownOf(2), "R1 foreign");
      bufN = 0;
      runBuf(32'h0000_0001, ownOf(1), "R1 empty");
      // R5 R7 sweep over bus sizes, own positions, root flag
      for (int n = 2; n <= 6; n++)
        for (int p = 0; p < n; p++)
          for (int r = 0; r < 2; r++) begin
            busBuf(n, p);
            runBuf(32'(p) | (32'(r) << 23), ownOf(p), "R4 R5 R7 sweep");
          end
      // R2 begin markers inside
      bufN = 0;
      bufQ[bufN++] = 32'hE0; bufQ[bufN++] = sidOf(0); bufQ[bufN++] = ~sidOf(0);
      bufQ[bufN++] = 32'hE0; bufQ[bufN++] = 32'hE0; bufQ[bufN++] = sidOf(2);
      bufQ[bufN++] = ~sidOf(2); bufQ[bufN++] = 32'h1;
      runBuf(32'h0000_0001, ownOf(1), "R2");
      // R3 end marker then trailing content
      bufN = 0;
      bufQ[bufN++] = 32'hE0; bufQ[bufN++] = sidOf(0); bufQ[bufN++] = ~sidOf(0);
      bufQ[bufN++] = 32'h1; bufQ[bufN++] = sidOf(2); bufQ[bufN++] = ~sidOf(2);
      bufQ[bufN++] = 32'hBAD0_0001;
      runBuf(32'h0080_0001, ownOf(1), "R3");
      // R6 unconnected, plain and with root insert as well
      bufN = 2; bufQ[0] = 32'hE0; bufQ[1] = 32'h1;
      runBuf(32'h0080_0000, ownOf(0), "R6");
      runBuf(32'h0080_0003, ownOf(3), "R6 R7");
      // R9 malformed quadlets, including a lone one before the end
      bufN = 0;
      bufQ[bufN++] = 32'hE0; bufQ[bufN++] = 32'hDEAD_0001; bufQ[bufN++] = sidOf(1);
      bufQ[bufN++] = ~sidOf(1); bufQ[bufN++] = sidOf(2); bufQ[bufN++] = sidOf(3);
      bufQ[bufN++] = ~sidOf(3); bufQ[bufN++] = 32'hDEAD_0002;
      runBuf(32'h0000_0002, ownOf(2), "R9");
      // R5 edge: phyId 63 never inserts; R8 other node-word bits ignored
      busBuf(4, 9);
      runBuf(32'hFF7F_FFFF, ownOf(63), "R5 R8 phy63");
    end
    // R9 saturation of the error counter
    gapMode = 0;
    bufN = 0;
    bufQ[bufN++] = 32'hE0;
    for (int k = 0; k < 300; k++) bufQ[bufN++] = 32'hDEAD_0100 + 32'(k);
    runBuf(32'h0000_0004, ownOf(4), "R9 saturate");
    chk(errCount == 8'hFF, "R9", $sformatf("errCount %0d expected 255", errCount));

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule